// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-side protocol engine of a serial memory that answers as a slave on a two-wire bus (one clock line, one open-drain data line). It samples the bus lines with a fast system clock and finds the bus conditions that open and close a command. It then decodes the control byte, takes in a two-byte word address and write data, and sends read data back. The only thing it drives onto the bus is an active-high pull-down request for the data line, which it uses for its acknowledge bits and for the read data bits.

Behind it sits a neighbour unit that holds the address pointer, the page buffer and the self-timed programming logic. The engine loads that pointer, hands over each received byte, asks for the pointer to move on after every byte it sends, and at the end of a write tells the unit either to program the buffered bytes or to drop them. The unit reports back while a programming cycle is running. Two chip-select straps, an enable strap and a write-protect input choose whether the engine answers and whether a write takes effect.

Top module: `ee2w_slave`

## Requirements
- R1: A Start is a falling edge on the synchronised data line while the synchronised clock line is high, and a Stop is a rising edge under the same condition. After a Stop the engine is idle and releases the data line (`sda_oe` = 0). Bytes clocked in without a Start get no acknowledge.
- R2: The control byte arrives MSB first. Bits 7:4 carry the device code (parameter, default 4'b1010), bit 3 is the block select, bits 2:1 are chip select (A1, A0) and bit 0 is read/write (1 = read). It is acknowledged only when the code matches, the chip-select bits equal `strap_cs` and `strap_en` is 1. Otherwise the data line stays released until the next Start or Stop.
- R3: In a write command the two bytes after the control byte are the word address, high byte first, and each one is acknowledged on the ninth clock. After the low byte, `ptr_load` pulses for one cycle with the new address on `ptr_addr`.
- R4: The block-select bit of the control byte appears as bit 16 of `ptr_addr`, above the 16-bit word address.
- R5: Each data byte after the address is acknowledged and shown on `wdata` with a one-cycle `wdata_valid`. A Stop that follows at least one data byte while `wp` = 0 gives a one-cycle `commit`.
- R6: While `wp` = 1 a write is still acknowledged in full. Its Stop gives a one-cycle `discard` and no `commit`, and the stored data keeps its old value.
- R7: While `wc_busy` = 1, a control byte equal to the one that started the last committed write gets no acknowledge. Any other valid control byte is acknowledged as usual.
- R8: A repeated Start after the address bytes keeps the loaded pointer, so a following read control byte returns the byte at that address (random read).
- R9: A read control byte returns `rd_data` at the current pointer, which is one past the last byte accessed. Bits go out MSB first, and `sda_oe` changes only while the clock line is low.
- R10: `rd_adv` pulses once for every byte sent, in the cycle the master's acknowledge bit is sampled. A master ACK (0) makes the next byte follow. A NACK (1) makes the engine release the data line and wait for a Start or Stop.
- R11: A Start or Stop in the middle of a byte aborts the command. Pending write data is handled by R5/R6 at a Stop and dropped with a one-cycle `discard` at a Start.
- R12: During and directly after reset, `sda_oe` is 0 and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_cs | input | 2 | Chip-select straps {A1, A0} |
| strap_en | input | 1 | Fixed enable strap, must be 1 to answer |
| wp | input | 1 | Write protect, sampled at Stop |
| wc_busy | input | 1 | Self-timed write cycle running |
| rd_data | input | 8 | Byte at the current pointer |
| ptr_load | output | 1 | Load pointer pulse |
| ptr_addr | output | 17 | Pointer value {block, high, low} |
| wdata_valid | output | 1 | Write byte pulse |
| wdata | output | 8 | Write byte |
| rd_adv | output | 1 | Advance pointer after a sent byte |
| commit | output | 1 | Program buffered bytes |
| discard | output | 1 | Drop buffered bytes |

## Verification
The assertions assume a well-behaved master. It changes the data line only while the clock line is low, except to make a Start or Stop. It never makes a Start or Stop while the engine pulls the data line low. Every bus phase also lasts several system clocks, so the synchroniser delay ends well inside each phase. The bench master keeps to all three: it drives the data line a quarter bit period after the clock falls, it issues Start and Stop only when the engine has released the line, and it holds each quarter bit for ten system clocks.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    localparam int BYTE_W  = 8;
    localparam int WADDR_W = 16;
    localparam int PTR_W   = WADDR_W + 1;
    localparam int BITC_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_TXW,
        S_SKIP
    } eng_st_e;

    typedef enum logic [1:0] {
        K_CTRL,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        eng_st_e           st;
        rx_kind_e          kind;
        logic [BITC_W-1:0] cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] ahi;
        logic [BYTE_W-1:0] cur_ctrl;
        logic [BYTE_W-1:0] busy_ctrl;
        logic [BYTE_W-1:0] wdata;
        logic [PTR_W-1:0]  ptr_addr;
        logic              blk;
        logic              sda_oe;
        logic              ack_ok;
        logic              rd_mode;
        logic              have_wd;
        logic              ptr_load;
        logic              wdv;
        logic              rd_adv;
        logic              commit;
        logic              discard;
    } eng_t;

endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // idle bus lines sit high, so reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= stage_d;
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ee2w_bus_events.sv
module ee2w_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign start    = prev_q.scl & scl_s & prev_q.sda & ~sda_s;
    assign stop     = prev_q.scl & scl_s & ~prev_q.sda & sda_s;
    assign scl_rise = ~prev_q.scl & scl_s;
    assign scl_fall = prev_q.scl & ~scl_s;

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        strap_cs,
    input  logic              strap_en,
    input  logic              wp,
    input  logic              wc_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_addr,
    output logic              wdata_valid,
    output logic [BYTE_W-1:0] wdata,
    output logic              rd_adv,
    output logic              commit,
    output logic              discard
);

    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       ev_start, ev_stop, ev_rise, ev_fall;

    ee2w_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    ee2w_bus_events i_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start    (ev_start),
        .stop     (ev_stop),
        .scl_rise (ev_rise),
        .scl_fall (ev_fall)
    );

    eng_t r_q, r_d;

    logic [BYTE_W-1:0] rx_byte;
    logic              id_ok;
    logic              poll_hit;
    logic              byte_done;

    assign rx_byte   = {r_q.sh[BYTE_W-2:0], sda_s};
    assign id_ok     = (rx_byte[7:4] == DEV_CODE) && (rx_byte[2:1] == strap_cs) && strap_en;
    assign poll_hit  = wc_busy && (rx_byte == r_q.busy_ctrl);
    assign byte_done = ev_rise && (r_q.st == S_RX) && (r_q.cnt == BITC_W'(BYTE_W - 1));

    always_comb begin
        r_d          = r_q;
        r_d.ptr_load = 1'b0;
        r_d.wdv      = 1'b0;
        r_d.rd_adv   = 1'b0;
        r_d.commit   = 1'b0;
        r_d.discard  = 1'b0;

        if (ev_stop) begin
            r_d.st     = S_IDLE;
            r_d.sda_oe = 1'b0;
            if (r_q.have_wd) begin
                r_d.have_wd = 1'b0;
                if (wp) begin
                    r_d.discard = 1'b1;
                end else begin
                    r_d.commit    = 1'b1;
                    r_d.busy_ctrl = r_q.cur_ctrl;
                end
            end
        end else if (ev_start) begin
            r_d.st      = S_RX;
            r_d.kind    = K_CTRL;
            r_d.cnt     = '0;
            r_d.sda_oe  = 1'b0;
            r_d.rd_mode = 1'b0;
            if (r_q.have_wd) begin
                r_d.have_wd = 1'b0;
                r_d.discard = 1'b1;
            end
        end else begin
            unique case (r_q.st)
                S_RX: begin
                    if (ev_rise && r_q.cnt < BITC_W'(BYTE_W)) begin
                        r_d.sh  = rx_byte;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (byte_done) begin
                            unique case (r_q.kind)
                                K_CTRL: begin
                                    r_d.ack_ok   = id_ok && !poll_hit;
                                    r_d.cur_ctrl = rx_byte;
                                    r_d.blk      = rx_byte[3];
                                    r_d.rd_mode  = rx_byte[0];
                                    r_d.kind     = K_AHI;
                                end
                                K_AHI: begin
                                    r_d.ack_ok = 1'b1;
                                    r_d.ahi    = rx_byte;
                                    r_d.kind   = K_ALO;
                                end
                                K_ALO: begin
                                    r_d.ack_ok   = 1'b1;
                                    r_d.ptr_load = 1'b1;
                                    r_d.ptr_addr = {r_q.blk, r_q.ahi, rx_byte};
                                    r_d.kind     = K_DATA;
                                end
                                default: begin
                                    r_d.ack_ok  = 1'b1;
                                    r_d.wdv     = 1'b1;
                                    r_d.wdata   = rx_byte;
                                    r_d.have_wd = 1'b1;
                                end
                            endcase
                        end
                    end else if (ev_fall && r_q.cnt == BITC_W'(BYTE_W)) begin
                        r_d.st     = r_q.ack_ok ? S_ACK : S_SKIP;
                        r_d.sda_oe = r_q.ack_ok;
                    end
                end
                S_ACK: begin
                    if (ev_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rd_mode) begin
                            r_d.st     = S_TX;
                            r_d.tx     = rd_data;
                            r_d.sda_oe = ~rd_data[BYTE_W-1];
                        end else begin
                            r_d.st     = S_RX;
                            r_d.sda_oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (ev_fall) begin
                        if (r_q.cnt == BITC_W'(BYTE_W - 1)) begin
                            r_d.st     = S_MACK;
                            r_d.sda_oe = 1'b0;
                        end else begin
                            r_d.tx     = r_q.tx << 1;
                            r_d.sda_oe = ~r_q.tx[BYTE_W-2];
                            r_d.cnt    = r_q.cnt + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (ev_rise) begin
                        r_d.rd_adv = 1'b1;
                        r_d.st     = sda_s ? S_SKIP : S_TXW;
                    end
                end
                S_TXW: begin
                    if (ev_fall) begin
                        r_d.st     = S_TX;
                        r_d.cnt    = '0;
                        r_d.tx     = rd_data;
                        r_d.sda_oe = ~rd_data[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe      = r_q.sda_oe;
    assign ptr_load    = r_q.ptr_load;
    assign ptr_addr    = r_q.ptr_addr;
    assign wdata_valid = r_q.wdv;
    assign wdata       = r_q.wdata;
    assign rd_adv      = r_q.rd_adv;
    assign commit      = r_q.commit;
    assign discard     = r_q.discard;

    // R9
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe);

    // R6
    wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!wp));

    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, discard, ptr_load, wdata_valid, rd_adv}));

endmodule

// File: tb/test_ee2w_slave.sv
module test_ee2w_slave;
    import ee2w_pkg::*;

    localparam int Q    = 10;
    localparam int BUSY = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    logic [1:0]       strap_cs = 2'b01;
    logic             strap_en = 1'b1;
    logic             wp = 1'b0;
    logic             wc_busy;
    logic [7:0]       rd_data = 8'h00;
    logic             ptr_load, wdata_valid, rd_adv, commit, discard;
    logic [PTR_W-1:0] ptr_addr;
    logic [7:0]       wdata;

    ee2w_slave i_ee2w_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .strap_cs(strap_cs), .strap_en(strap_en), .wp(wp), .wc_busy(wc_busy),
        .rd_data(rd_data), .ptr_load(ptr_load), .ptr_addr(ptr_addr),
        .wdata_valid(wdata_valid), .wdata(wdata), .rd_adv(rd_adv),
        .commit(commit), .discard(discard)
    );

    int n_tests = 0, n_fail = 0;
    int n_commit = 0, n_discard = 0;

    function automatic logic [7:0] seed(input logic [16:0] a);
        return a[7:0] ^ 8'h2B ^ (a[16] ? 8'h80 : 8'h00);
    endfunction

    // neighbour unit model: pointer, page buffer, write timer
    logic [7:0]  mem [int];
    int          pend_a[$];
    logic [7:0]  pend_d[$];
    int          busy_cnt = 0;
    logic [16:0] m_ptr = '0;
    assign wc_busy = (busy_cnt > 0);

    always @(posedge clk) begin
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (ptr_load) m_ptr <= ptr_addr;
        if (wdata_valid) begin
            pend_a.push_back(int'(m_ptr));
            pend_d.push_back(wdata);
            m_ptr <= {m_ptr[16:7], m_ptr[6:0] + 7'd1};
        end
        if (rd_adv) m_ptr <= {m_ptr[16], m_ptr[15:0] + 16'd1};
        if (commit) begin
            foreach (pend_a[i]) mem[pend_a[i]] = pend_d[i];
            pend_a.delete(); pend_d.delete();
            busy_cnt <= BUSY;
            n_commit++;
        end
        if (discard) begin
            pend_a.delete(); pend_d.delete();
            n_discard++;
        end
    end

    always @(negedge clk) rd_data = mem.exists(int'(m_ptr)) ? mem[int'(m_ptr)] : seed(m_ptr);

    // scoreboard
    logic [7:0] exp_q[$], got_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0 && got_q.size() > 0) begin
            logic [7:0] e, g;
            string t;
            e = exp_q.pop_front(); g = got_q.pop_front(); t = tag_q.pop_front();
            chk(g == e, t, "read byte", int'(g), int'(e));
        end
    end

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(Q); m_scl = 1'b1; qw(Q); m_sda = 1'b0; qw(Q); m_scl = 1'b0; qw(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(Q); m_scl = 1'b1; qw(Q); m_sda = 1'b1; qw(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; qw(Q); m_scl = 1'b1; qw(2 * Q); m_scl = 1'b0; qw(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; qw(Q); m_scl = 1'b1; qw(Q); b = sda_bus; qw(Q); m_scl = 1'b0; qw(Q);
    endtask

    task automatic tx_byte(input logic [7:0] d, input bit exp_ack, input string tag);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        chk((!b) == exp_ack, tag, "ack bit", int'(!b), int'(exp_ack));
    endtask

    task automatic rx_byte(input bit mack, input logic [7:0] e, input string tag);
        logic [7:0] d;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!mack);
        exp_q.push_back(e); tag_q.push_back(tag); got_q.push_back(d);
    endtask

    task automatic set_addr(input logic [7:0] ctrl, input logic [15:0] a, input string tag);
        bus_start();
        tx_byte(ctrl, 1'b1, tag);
        tx_byte(a[15:8], 1'b1, tag);
        tx_byte(a[7:0], 1'b1, tag);
    endtask

    task automatic wait_idle();
        while (wc_busy) qw(1);
        qw(4);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        int c0, d0;
        qw(3);
        // R12 reset state
        chk(sda_oe == 1'b0, "R12", "sda_oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        qw(3);
        chk({sda_oe, commit, discard, ptr_load, rd_adv, wdata_valid} == '0, "R12", "outputs after reset",
            int'({sda_oe, commit, discard, ptr_load, rd_adv, wdata_valid}), 0);

        // R3 R5 byte write at block 0, address 0123 (ctrl 1010_0_01_0 = A2)
        set_addr(8'hA2, 16'h0123, "R3");
        chk(ptr_addr == 17'h00123, "R3", "ptr_addr", int'(ptr_addr), 'h00123);
        tx_byte(8'hA5, 1'b1, "R5");
        bus_stop(); qw(4);
        chk(n_commit == 1, "R5", "commit count", n_commit, 1);

        // R7 polling while busy
        bus_start(); tx_byte(8'hA2, 1'b0, "R7"); bus_stop();
        bus_start(); tx_byte(8'hAA, 1'b1, "R7"); bus_stop();
        wait_idle();
        bus_start(); tx_byte(8'hA2, 1'b1, "R7"); bus_stop();

        // R4 page write to block 1 (ctrl 1010_1_01_0 = AA)
        set_addr(8'hAA, 16'h0123, "R4");
        chk(ptr_addr == 17'h10123, "R4", "ptr_addr block bit", int'(ptr_addr), 'h10123);
        tx_byte(8'h3C, 1'b1, "R5");
        tx_byte(8'h7E, 1'b1, "R5");
        bus_stop(); qw(4);
        chk(n_commit == 2, "R5", "commit count", n_commit, 2);
        wait_idle();

        // R8 random read, R10 NACK releases line
        set_addr(8'hA2, 16'h0123, "R8");
        bus_start(); tx_byte(8'hA3, 1'b1, "R8");
        rx_byte(1'b0, 8'hA5, "R8");
        chk(sda_oe == 1'b0, "R10", "released after NACK", int'(sda_oe), 0);
        bus_stop();

        // R9 current address read
        bus_start(); tx_byte(8'hA3, 1'b1, "R9");
        rx_byte(1'b0, seed(17'h00124), "R9");
        bus_stop();

        // R10 sequential read in block 1
        set_addr(8'hAA, 16'h0123, "R10");
        bus_start(); tx_byte(8'hAB, 1'b1, "R10");
        rx_byte(1'b1, 8'h3C, "R10");
        rx_byte(1'b1, 8'h7E, "R10");
        rx_byte(1'b0, seed(17'h10125), "R10");
        bus_stop();

        // R6 write protect
        wp = 1'b1;
        c0 = n_commit; d0 = n_discard;
        set_addr(8'hA2, 16'h0123, "R6");
        tx_byte(8'h11, 1'b1, "R6");
        bus_stop(); qw(4);
        wp = 1'b0;
        chk(n_discard == d0 + 1, "R6", "discard count", n_discard, d0 + 1);
        chk(n_commit == c0, "R6", "commit count", n_commit, c0);
        set_addr(8'hA2, 16'h0123, "R6");
        bus_start(); tx_byte(8'hA3, 1'b1, "R6");
        rx_byte(1'b0, 8'hA5, "R6");
        bus_stop();

        // R2 identity checks
        bus_start(); tx_byte(8'hB2, 1'b0, "R2"); bus_stop();
        bus_start(); tx_byte(8'hA4, 1'b0, "R2"); bus_stop();
        strap_en = 1'b0;
        bus_start(); tx_byte(8'hA2, 1'b0, "R2"); bus_stop();
        strap_en = 1'b1;

        // R1 byte without a Start is ignored
        m_scl = 1'b0; qw(Q);
        tx_byte(8'hA2, 1'b0, "R1");
        bus_stop();

        // R11 Start inside a byte aborts, then a full random read works
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        set_addr(8'hA2, 16'h0123, "R11");
        bus_start(); tx_byte(8'hA3, 1'b1, "R11");
        rx_byte(1'b0, 8'hA5, "R11");
        bus_stop();

        // R11 data then repeated Start is dropped
        c0 = n_commit; d0 = n_discard;
        set_addr(8'hA2, 16'h0050, "R11");
        tx_byte(8'h99, 1'b1, "R11");
        bus_start(); bus_stop(); qw(4);
        chk(n_discard == d0 + 1, "R11", "discard on Start", n_discard, d0 + 1);
        chk(n_commit == c0, "R11", "no commit", n_commit, c0);
        set_addr(8'hA2, 16'h0050, "R11");
        bus_start(); tx_byte(8'hA3, 1'b1, "R11");
        rx_byte(1'b0, seed(17'h00050), "R11");
        bus_stop();

        qw(20);
        chk(exp_q.size() == 0 && got_q.size() == 0, "R9", "scoreboard drained",
            got_q.size(), exp_q.size());
        summary();
    end

endmodule